// File: doc/BRIEF.md
# Byte-Lane Scratch Register Bank

This block is a small memory-mapped register bank for a bus that is 32 bits wide and word-aligned, where each physical word carries a single meaningful byte in its low eight bits. A wider logical value is spread over a run of consecutive physical words, four bytes apart. The most significant byte sits at the lowest address of the run.

The bank holds a control word and one logical scratch register. Software uses the scratch register at boot to confirm that bus access and byte ordering work. It reads the power-on pattern, writes a test pattern, reads that back, and restores the original. Software splits a 32-bit value into four single-byte word writes, high byte first, and joins four word reads back together. Access uses the processor's native byte order, and the hardware never swaps bytes at run time.

Each subregister write takes effect at once, with no shadow latch. A logical value that has been only partly written is therefore visible between accesses. Bit 0 of the control word is a self-clearing strobe that reloads the scratch register with its reset value.

Top module: `bytelane_csr_bank`

## Requirements
- R1: After reset, the scratch register holds 0x12345678. Reads of the byte offsets 0x04, 0x08, 0x0C and 0x10 return 0x12, 0x34, 0x56 and 0x78 in that order: subregister index 0 holds the most significant byte.
- R2: Read data appears on `rd_data` in the cycle after `rd_en` was sampled high. Bits 31:8 of `rd_data` are always zero. `rd_data` is zero in any cycle that follows a cycle with `rd_en` low.
- R3: A write to one scratch subregister replaces only that byte, from the next clock edge. The other bytes keep their values, so a partly written value is readable.
- R4: Bits 31:8 of `wr_data` are ignored on every write. Only `wr_data[7:0]` is stored.
- R5: Writing 0xde, 0xad, 0xbe and 0xef to the four scratch subregisters makes a 32-bit read-back of 0xdeadbeef. Writing the reset pattern afterwards restores 0x12345678.
- R6: A write to offset 0x00 with `wr_data[0]`=1 reloads the scratch register with 0x12345678 at the next edge. A write there with bit 0 clear changes nothing. Offset 0x00 always reads zero.
- R7: Offsets outside 0x00 to 0x10, and any address with bit 1 or bit 0 set, read as zero. Writes to them leave the scratch register unchanged.
- R8: When a read and a write hit the same subregister in the same cycle, the read returns the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (8) | Byte address within the bank |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data; only bits 7:0 are used |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 32 | Registered read data; bits 31:8 are zero |

## Verification
The bench reads the reset value byte by byte, so a design that placed the least significant byte at the lowest address would return 0x78 first. It writes single subregisters and reads the whole value back. A design with a shadow latch, or with a byte-enable decode one word off, would show stale or misplaced bytes. It sends writes with junk in the upper bits and writes to misaligned and out-of-range addresses. A design that stored the wide data, or decoded the address loosely, would read back nonzero upper bits or a corrupted scratch value. It also fires the soft-reset strobe, both set and clear, and issues a read and a write to one subregister in the same cycle. A design that forwarded the write data would return the new byte instead of the old one.

// File: rtl/bytelane_csr_bank.sv
module bytelane_csr_bank #(
  parameter int          ADDR_W        = 8,
  parameter int          SCRATCH_BYTES = 4,
  parameter int          SCRATCH_OFF   = 4,
  parameter logic [31:0] SCRATCH_INIT  = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int SCR_W  = 8 * SCRATCH_BYTES;
  localparam int BASE_W = SCRATCH_OFF / 4;

  logic [IDX_W-1:0]         word_idx;
  logic                     aligned;
  logic                     ctrl_sel;
  logic                     soft_rst;
  logic [SCRATCH_BYTES-1:0] byte_sel;
  logic [SCR_W-1:0]         scratch_q;
  logic [SCR_W-1:0]         init_val;
  logic [7:0]               rd_byte;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign ctrl_sel = aligned && (word_idx == '0);
  assign soft_rst = wr_en && ctrl_sel && wr_data[0];
  assign init_val = SCR_W'(SCRATCH_INIT);

  for (genvar i = 0; i < SCRATCH_BYTES; i++) begin : g_lane
    localparam int LSB = 8 * (SCRATCH_BYTES - 1 - i);
    assign byte_sel[i] = aligned && (word_idx == IDX_W'(BASE_W + i));
    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst)
        scratch_q[LSB +: 8] <= init_val[LSB +: 8];
      else if (wr_en && byte_sel[i])
        scratch_q[LSB +: 8] <= wr_data[7:0];
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < SCRATCH_BYTES; i++)
      if (byte_sel[i]) rd_byte = scratch_q[8*(SCRATCH_BYTES-1-i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= {24'h0, rd_byte};
    else            rd_data <= '0;
  end
endmodule

module bytelane_csr_bank_chk #(
  parameter int          ADDR_W        = 8,
  parameter int          SCRATCH_BYTES = 4,
  parameter int          SCRATCH_OFF   = 4,
  parameter logic [31:0] SCRATCH_INIT  = 32'h1234_5678
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wr_en,
  input logic [31:0]                wr_data,
  input logic                       rd_en,
  input logic [31:0]                rd_data,
  input logic [8*SCRATCH_BYTES-1:0] scratch
);
  localparam int SCR_W = 8 * SCRATCH_BYTES;
  localparam int TOP_A = SCRATCH_OFF + 4 * (SCRATCH_BYTES - 1);

  logic in_map;
  assign in_map = (addr[1:0] == 2'b00) &&
                  ((int'(addr) == 0) ||
                   ((int'(addr) >= SCRATCH_OFF) && (int'(addr) <= TOP_A)));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'h0);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == 32'h0);

  p_first_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == SCRATCH_OFF) |=>
      (scratch[SCR_W-1 -: 8] == $past(wr_data[7:0])) &&
      (scratch[SCR_W-9:0] == $past(scratch[SCR_W-9:0])));

  p_soft_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wr_data[0]) |=> scratch == SCR_W'(SCRATCH_INIT));

  p_unmapped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_map) |=> $stable(scratch));
endmodule

bind bytelane_csr_bank bytelane_csr_bank_chk #(
  .ADDR_W(ADDR_W), .SCRATCH_BYTES(SCRATCH_BYTES),
  .SCRATCH_OFF(SCRATCH_OFF), .SCRATCH_INIT(SCRATCH_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .scratch(scratch_q)
);

// File: tb/bytelane_csr_bank_tb.sv
`timescale 1ns/1ps
module bytelane_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bytelane_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [31:0] b;
    v = '0;
    for (int i = 0; i < 4; i++) begin
      rd(8'(4 + 4*i), b);
      v = (v << 8) | {24'h0, b[7:0]};
    end
  endtask

  task automatic wr32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(8'(4 + 4*i), {24'h0, v[31-8*i -: 8]});
  endtask

  task automatic t_reset_r1;
    logic [31:0] d;
    check("R2 reset rd_data", rd_data, 32'h0);
    rd(8'h04, d); check("R1 byte idx0", d, 32'h12);
    rd(8'h08, d); check("R1 byte idx1", d, 32'h34);
    rd(8'h0C, d); check("R1 byte idx2", d, 32'h56);
    rd(8'h10, d); check("R1 byte idx3", d, 32'h78);
  endtask

  task automatic t_idle_r2;
    logic [31:0] d;
    rd(8'h04, d);
    @(negedge clk); check("R2 idle after read", rd_data, 32'h0);
  endtask

  task automatic t_partial_r3;
    logic [31:0] v;
    wr(8'h08, 32'h0000_00A5);
    rd32(v); check("R3 partial write", v, 32'h12A5_5678);
    wr(8'h10, 32'h0000_0001);
    rd32(v); check("R3 second lane", v, 32'h12A5_5601);
  endtask

  task automatic t_upper_r4;
    logic [31:0] d;
    wr(8'h0C, 32'hFFFF_FF3C);
    rd(8'h0C, d); check("R4 upper bits ignored", d, 32'h0000_003C);
  endtask

  task automatic t_full_r5;
    logic [31:0] v;
    wr32(32'hDEAD_BEEF);
    rd32(v); check("R5 full readback", v, 32'hDEAD_BEEF);
    wr32(32'h1234_5678);
    rd32(v); check("R5 restore", v, 32'h1234_5678);
  endtask

  task automatic t_soft_r6;
    logic [31:0] v;
    wr32(32'hCAFE_F00D);
    wr(8'h00, 32'hFFFF_FFFE);
    rd32(v); check("R6 bit0 clear no effect", v, 32'hCAFE_F00D);
    wr(8'h00, 32'h0000_0001);
    rd32(v); check("R6 soft reset reload", v, 32'h1234_5678);
    rd(8'h00, v); check("R6 control reads zero", v, 32'h0);
  endtask

  task automatic t_unmapped_r7;
    logic [31:0] v;
    wr(8'h14, 32'h0000_00FF);
    wr(8'h05, 32'h0000_00EE);
    wr(8'h02, 32'h0000_0001);
    wr(8'hFC, 32'h0000_0077);
    rd32(v); check("R7 unmapped writes ignored", v, 32'h1234_5678);
    rd(8'h14, v); check("R7 read 0x14", v, 32'h0);
    rd(8'h05, v); check("R7 read misaligned", v, 32'h0);
    rd(8'hFC, v); check("R7 read high", v, 32'h0);
  endtask

  task automatic t_same_r8;
    logic [31:0] d;
    @(negedge clk); addr = 8'h08; wr_data = 32'h99; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); d = rd_data; wr_en = 1'b0; rd_en = 1'b0;
    check("R8 read returns old byte", d, 32'h34);
    rd(8'h08, d); check("R8 write took effect", d, 32'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_idle_r2();
    t_partial_r3();
    t_upper_r4();
    t_full_r5();
    t_soft_r6();
    t_unmapped_r7();
    t_same_r8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule